// File: doc/BRIEF.md
# Bus-programmed trim code register with retained copy

This block is a serial-bus target that owns one 7-bit trim code. The code drives the input of a 128-step current DAC that sits outside the block. A controller on a two-wire bus (SCL clock, SDA open-drain data) addresses the block at the fixed 7-bit address 1001111. It can then do one of three things: load a new code into the live register, program the code into a retained copy that survives a warm reset, or read back the live code. The retained copy stands in for a non-volatile cell. Programming it starts a long busy window, and during that window the block refuses write accesses.

Both bus lines are sampled with the system clock. Each line passes through a synchroniser and a glitch filter before START, STOP and clock-edge events are decoded. The transfer engine is a single state machine:
- IDLE waits for a START.
- ADDR shifts in the address byte.
- ADDR_ACK (`ST_AACK`) drives the acknowledge.
- Write transfers go through WR_DATA (`ST_WDAT`) and WR_ACK (`ST_WACK`).
- Read transfers go through RD_DATA (`ST_RDAT`) and RD_ACK (`ST_RACK`).
- SKIP ignores the bus until the next START or STOP.

The transitions are:
- A START moves any state to ADDR.
- A STOP moves any state to IDLE.
- ADDR moves to ADDR_ACK on a match that may be served. Otherwise it moves to SKIP.
- ADDR_ACK moves to RD_DATA or WR_DATA, depending on the direction bit.
- WR_DATA moves to WR_ACK after eight bits, and WR_ACK then moves to SKIP.
- RD_DATA moves to RD_ACK after eight bits, and RD_ACK then moves to IDLE.

Two resets are provided. The cold reset `por_n` restores the retained copy to its shipped value. The warm reset `rst_n` reloads the live register from the retained copy.

Top module: `vcal_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1001111. Bit 0 is the direction bit: 1 selects a read and 0 selects a write. Any other address is not acknowledged, and the transfer is then ignored.
- R2: A write carries one data byte, sent MSB first. Bits 7..1 are the code and bit 0 is the target select. When bit 0 is 1, the live register and the `dac_code` output take the code.
- R3: When the target select bit is 0, the code is programmed into the retained copy and the live register is left unchanged.
- R4: A read returns one byte whose bits 7..1 are the live code and whose bit 0 is 0.
- R5: Every address or write-data byte that the block accepts is acknowledged by pulling SDA low during the ninth clock.
- R6: Once programming starts, write addresses are not acknowledged for PROG_CYCLES clock cycles. Reads are still served during that window, and writes are acknowledged again after it ends.
- R7: After a cold reset, the retained copy holds the code 64 (byte pattern 80h), and the live code equals 64.
- R8: A warm reset copies the retained code into the live register.
- R9: While `wr_unlock` is low, writes are still acknowledged but change neither the live register nor the retained copy.
- R10: A pulse on SDA shorter than FILT_LEN clock cycles is rejected and does not create a START or STOP.
- R11: After the read byte, the block releases SDA for the master's acknowledge slot. It then returns to idle whether the master sends ACK or NACK, and serves the next START.
- R12: A STOP in the middle of a byte aborts the transfer with no update. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| por_n | input | 1 | Cold reset, active low, synchronous; restores the retained copy |
| rst_n | input | 1 | Warm reset, active low, synchronous; recalls the retained copy into the live register |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| wr_unlock | input | 1 | High permits writes; low protects both targets |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| dac_code | output | 7 | Live trim code for the DAC |

## Verification
The bound checker watches the following on every cycle:
- The live code changes only at the end of an unlocked write-data byte.
- The retained copy changes only when it is not busy and writes are unlocked.
- The busy window opens only out of a write-data byte.
- SDA is never pulled in idle or in the master's acknowledge slot.
- SDA is held low through each acknowledge.

The following can only be shown by the bench's transfers at the pins:
- The address match and mismatch.
- The read byte layout.
- The recall on warm reset.
- The refusal of writes during the busy window, and its expiry.
- Glitch rejection.
- Aborted and restarted transfers.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
    localparam int CODE_W = 7;
    localparam int BYTE_W = CODE_W + 1;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } slv_state_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 4,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RST_VAL}};
            hist_q <= {FILT_LEN{RST_VAL}};
            filt   <= RST_VAL;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                filt <= 1'b1;
            else if (~|hist_q)
                filt <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_events.sv
module bus_events #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wr_unlock,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl,
    output logic wp_ok
);
    localparam int          N_LINES  = 3;
    localparam logic [2:0]  RST_PAT  = 3'b011;   // {unlock, sda, scl}

    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] filt_v;
    logic               scl_q, sda_q;

    assign raw_v = {wr_unlock, sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN),
            .RST_VAL    (RST_PAT[g])
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[g]),
            .filt (filt_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= filt_v[0];
            sda_q <= filt_v[1];
        end
    end

    assign scl_rise  = filt_v[0] & ~scl_q;
    assign scl_fall  = ~filt_v[0] & scl_q;
    assign start_det = filt_v[0] & scl_q & sda_q & ~filt_v[1];
    assign stop_det  = filt_v[0] & scl_q & ~sda_q & filt_v[1];
    assign sda_lvl   = filt_v[1];
    assign wp_ok     = filt_v[2];
endmodule

// File: rtl/nv_cell.sv
module nv_cell #(
    parameter int CODE_W      = 7,
    parameter int NV_INIT     = 64,
    parameter int PROG_CYCLES = 10_000_000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              prog_req,
    input  logic [CODE_W-1:0] prog_code,
    output logic [CODE_W-1:0] nv_code,
    output logic              nv_busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            nv_code  <= CODE_W'(NV_INIT);
            busy_cnt <= '0;
        end else if (prog_req) begin
            nv_code  <= prog_code;
            busy_cnt <= CNT_LOAD;
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign nv_busy = (busy_cnt != '0);
endmodule

// File: rtl/vcal_slave.sv
module vcal_slave
    import vcal_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1001111,
    parameter int         NV_INIT     = 64,
    parameter int         PROG_CYCLES = 10_000_000,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              wr_unlock,
    output logic              sda_oe,
    output logic [CODE_W-1:0] dac_code
);
    localparam int               BIT_W    = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W);

    slv_state_e          st, st_n;
    logic [BIT_W-1:0]    bitcnt;
    logic [BYTE_W-1:0]   rx, tx;
    logic                rw;
    logic [CODE_W-1:0]   dac;
    logic                scl_rise, scl_fall, start_det, stop_det, sda_lvl, wp_ok;
    logic                commit, commit_dac, commit_nv, drive_low, byte_done;
    logic [CODE_W-1:0]   nv_code;
    logic                nv_busy;

    bus_events #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .wr_unlock(wr_unlock),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_lvl  (sda_lvl),
        .wp_ok    (wp_ok)
    );

    nv_cell #(
        .CODE_W     (CODE_W),
        .NV_INIT    (NV_INIT),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_nv (
        .clk      (clk),
        .por_n    (por_n),
        .prog_req (commit_nv),
        .prog_code(rx[BYTE_W-1:1]),
        .nv_code  (nv_code),
        .nv_busy  (nv_busy)
    );

    assign byte_done = scl_fall && (bitcnt == BIT_LAST);

    // next-state decode
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: st_n = ST_IDLE;
            ST_ADDR:
                if (byte_done)
                    st_n = (rx[BYTE_W-1:1] == DEV_ADDR && (rx[0] || !nv_busy))
                           ? ST_AACK : ST_SKIP;
            ST_AACK: if (scl_fall)  st_n = rw ? ST_RDAT : ST_WDAT;
            ST_WDAT: if (byte_done) st_n = ST_WACK;
            ST_WACK: if (scl_fall)  st_n = ST_SKIP;
            ST_RDAT: if (byte_done) st_n = ST_RACK;
            ST_RACK: if (scl_fall)  st_n = ST_IDLE;
            ST_SKIP: st_n = ST_SKIP;
            default: st_n = ST_IDLE;
        endcase
        if (stop_det)  st_n = ST_IDLE;
        if (start_det) st_n = ST_ADDR;
    end

    assign commit     = (st == ST_WDAT) && (st_n == ST_WACK) && wp_ok;
    assign commit_dac = commit &&  rx[0];
    assign commit_nv  = commit && !rx[0];

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            rx     <= '0;
            tx     <= '0;
            rw     <= 1'b0;
            dac    <= nv_code;
        end else begin
            st <= st_n;
            if (st_n != st || start_det)
                bitcnt <= '0;
            else if (scl_rise && (st == ST_ADDR || st == ST_WDAT || st == ST_RDAT))
                bitcnt <= bitcnt + 1'b1;
            if (scl_rise && (st == ST_ADDR || st == ST_WDAT))
                rx <= {rx[BYTE_W-2:0], sda_lvl};
            if (st == ST_ADDR && st_n == ST_AACK)
                rw <= rx[0];
            if (st_n == ST_RDAT && st != ST_RDAT)
                tx <= {dac, 1'b0};
            else if (st == ST_RDAT && scl_fall)
                tx <= {tx[BYTE_W-2:0], 1'b0};
            if (commit_dac)
                dac <= rx[BYTE_W-1:1];
        end
    end

    // output decode
    always_comb begin
        unique case (st)
            ST_AACK, ST_WACK: drive_low = 1'b1;
            ST_RDAT:          drive_low = ~tx[BYTE_W-1];
            default:          drive_low = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sda_oe <= 1'b0;
        else
            sda_oe <= drive_low;
    end

    assign dac_code = dac;
endmodule

// File: rtl/vcal_slave_chk.sv
module vcal_slave_chk
    import vcal_pkg::*;
(
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              sda_oe,
    input logic [CODE_W-1:0] dac_code,
    input slv_state_e        st,
    input logic [CODE_W-1:0] nv_code,
    input logic              nv_busy,
    input logic              wp_ok
);
    // R2
    dac_update_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !$stable(dac_code) |-> ($past(st) == ST_WDAT && $past(wp_ok)));

    // R9
    nv_update_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !$stable(nv_code) |-> ($past(st) == ST_WDAT && $past(wp_ok) && !$past(nv_busy)));

    // R6
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(nv_busy) |-> ($past(st) == ST_WDAT));

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ((st == ST_IDLE || st == ST_RACK) && $past(st) == st) |-> !sda_oe);

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ((st == ST_AACK || st == ST_WACK) && $past(st) == st) |-> sda_oe);
endmodule

bind vcal_slave vcal_slave_chk u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .dac_code(dac_code),
    .st      (st),
    .nv_code (nv_code),
    .nv_busy (nv_busy),
    .wp_ok   (wp_ok)
);

// File: tb/vcal_slave_tb.sv
module vcal_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int PROG       = 3000;
    localparam logic [6:0] ADDR = 7'b1001111;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, unlock = 1'b0;
    logic       sda_oe;
    logic [6:0] dac_code;
    wire        sda_line = sda_m & ~sda_oe;

    int total = 0, fails = 0;
    logic [6:0] exp_dac;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcal_slave #(.PROG_CYCLES(PROG), .FILT_LEN(4)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .scl_in(scl_m),
        .sda_in(sda_line), .wr_unlock(unlock), .sda_oe(sda_oe), .dac_code(dac_code)
    );

    function automatic logic [7:0] rd_byte(input logic [6:0] c);
        return {c, 1'b0};
    endfunction
    function automatic logic [7:0] wr_byte(input logic [6:0] c, input logic p);
        return {c, p};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0;
    endtask
    task automatic bus_stop;
        w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask
    task automatic bit_out(input logic b, input logic glitch);
        w(Q); sda_m = b; w(Q); scl_m = 1'b1;
        if (glitch) begin
            w(5); sda_m = 1'b0; w(2); sda_m = 1'b1; w(2 * Q - 7);
        end else begin
            w(2 * Q);
        end
        scl_m = 1'b0;
    endtask
    task automatic bit_in(output logic v);
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); v = sda_line; w(Q); scl_m = 1'b0;
    endtask
    task automatic send(input logic [7:0] b, input int glitch_bit, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) bit_out(b[i], i == glitch_bit);
        bit_in(v);
        ack = ~v;
    endtask
    task automatic recv(input logic m_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
        bit_out(~m_ack, 1'b0);
    endtask

    task automatic do_write(input logic [6:0] c, input logic p, output logic a1, output logic a2);
        bus_start;
        send({ADDR, 1'b0}, -1, a1);
        a2 = 1'b0;
        if (a1) send(wr_byte(c, p), -1, a2);
        bus_stop;
    endtask
    task automatic do_read(output logic a1, output logic [7:0] b);
        bus_start;
        send({ADDR, 1'b1}, -1, a1);
        b = 8'hxx;
        if (a1) recv(1'b0, b);
        bus_stop;
    endtask
    task automatic warm_reset;
        rst_n = 1'b0; w(5); rst_n = 1'b1; w(5);
    endtask

    initial begin
        repeat (180_000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic a1, a2;
        logic [7:0] b;
        int seed;
        seed = $urandom(32'h5eed);

        w(10); por_n = 1'b1; rst_n = 1'b1; w(10);
        // R7 cold reset value
        chk("R7 reset code", dac_code, 64);
        chk("R7 reset oe", sda_oe, 0);
        do_read(a1, b);
        chk("R5 read addr ack", a1, 1);
        chk("R4 R7 read byte", b, 8'h80);
        exp_dac = 7'd64;

        // R9 locked write acked, no change
        unlock = 1'b0;
        do_write(7'h33, 1'b1, a1, a2);
        chk("R9 locked acks", {a1, a2}, 2'b11);
        chk("R9 locked dac", dac_code, 64);

        unlock = 1'b1; w(5);
        do_write(7'h33, 1'b1, a1, a2);
        chk("R5 write acks", {a1, a2}, 2'b11);
        chk("R2 dac load", dac_code, 7'h33);
        do_read(a1, b);
        chk("R4 readback", b, rd_byte(7'h33));

        // R1 wrong address
        bus_start; send({7'b1001110, 1'b0}, -1, a1); bus_stop;
        chk("R1 mismatch nack", a1, 0);
        chk("R1 dac kept", dac_code, 7'h33);

        // R3 program retained copy
        do_write(7'h15, 1'b0, a1, a2);
        chk("R3 prog acks", {a1, a2}, 2'b11);
        chk("R3 dac untouched", dac_code, 7'h33);
        // R6 busy window
        bus_start; send({ADDR, 1'b0}, -1, a1); bus_stop;
        chk("R6 busy write nack", a1, 0);
        do_read(a1, b);
        chk("R6 busy read ack", a1, 1);
        chk("R6 busy read data", b, rd_byte(7'h33));
        w(PROG + 200);
        do_write(7'h70, 1'b1, a1, a2);
        chk("R6 after window ack", {a1, a2}, 2'b11);
        chk("R6 after window dac", dac_code, 7'h70);

        // R9 locked programming leaves retained copy
        unlock = 1'b0; w(5);
        do_write(7'h01, 1'b0, a1, a2);
        chk("R9 locked prog ack", {a1, a2}, 2'b11);
        unlock = 1'b1;
        warm_reset;
        chk("R8 R3 R9 recall", dac_code, 7'h15);

        // R11 master ACK after read, then back to idle and served again
        bus_start; send({ADDR, 1'b1}, -1, a1); recv(1'b1, b);
        w(Q);
        chk("R11 released after ack slot", sda_oe, 0);
        bus_stop;
        chk("R11 read data", b, rd_byte(7'h15));
        do_read(a1, b);
        chk("R11 next read", b, rd_byte(7'h15));

        // R10 glitch during a data bit
        bus_start; send({ADDR, 1'b0}, -1, a1); send(wr_byte(7'h7F, 1'b1), 3, a2); bus_stop;
        chk("R10 glitch rejected", dac_code, 7'h7F);

        // R12 stop mid-byte
        bus_start; send({ADDR, 1'b0}, -1, a1);
        for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
        bus_stop;
        chk("R12 abort no change", dac_code, 7'h7F);
        // R12 repeated start
        bus_start; send({ADDR, 1'b0}, -1, a1);
        bus_start; send({ADDR, 1'b1}, -1, a2); recv(1'b0, b); bus_stop;
        chk("R12 restart ack", a2, 1);
        chk("R12 restart data", b, rd_byte(7'h7F));
        exp_dac = 7'h7F;

        // random mix
        for (int k = 0; k < 30; k++) begin
            int op;
            logic [6:0] c;
            op = $urandom % 3;
            c = 7'($urandom);
            if (op == 0) begin
                unlock = ($urandom % 4) != 0; w(5);
                do_write(c, 1'b1, a1, a2);
                if (unlock) exp_dac = c;
                chk("R2 R9 random write", dac_code, exp_dac);
            end else if (op == 1) begin
                do_read(a1, b);
                chk("R4 random read", b, rd_byte(exp_dac));
            end else begin
                logic [6:0] bad;
                bad = 7'($urandom);
                if (bad == ADDR) bad = bad ^ 7'h01;
                bus_start; send({bad, 1'b0}, -1, a1); bus_stop;
                chk("R1 random mismatch", a1, 0);
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule